// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from eight sources and presents one of them at a time to a processor core. Each source has its own bit in a pending register. The bit is set when the source's request line rises. It stays set until the core acknowledges that source by its index.

At the start of every instruction fetch, the core pulses a sample strobe. On that strobe the controller takes the lowest-indexed pending source that is allowed to interrupt. Index 0 is the power-fail source and has the highest priority. Index 7 is the I/O completion source and has the lowest. The controller then latches the handler address for that source. The address is a programmable 16-bit base plus the 8-bit offset supplied by the winning device, so a handler can sit anywhere in memory. The address and the chosen index stay frozen until the acknowledge arrives.

A global disable input blocks signalling for every source except power fail. Requests that arrive while the disable is high are still recorded.

Top module: `vic_top`

## Requirements
- R1: After reset, irq_o is 0, vec_o is 0 and idx_o is 0, and no source is pending, so a sample strobe with no request raises nothing.
- R2: A pending bit is set by a 0-to-1 transition on its req_i bit. A request held high after being acknowledged does not set the bit again until it drops and rises.
- R3: A pending bit is cleared only by ack_i while an interrupt is held with ack_idx_i equal to idx_o. An acknowledge with any other index changes nothing, and irq_o stays 1.
- R4: Pending bits affect irq_o, vec_o and idx_o only on a cycle with sample_i high while no interrupt is held. The outputs appear in the cycle after that strobe edge.
- R5: On a sample, the lowest-indexed eligible pending source wins. Index 0 (power fail) is highest and index 7 (I/O) is lowest.
- R6: vec_o equals base + offset of the winning source, modulo 2^16. The offset is taken from bits [8*i+7:8*i] of off_i at the sample edge and is zero-extended.
- R7: From the sample edge until the matching acknowledge, vec_o and idx_o hold still. Later requests and changes to off_i or the base are ignored during that time.
- R8: While gdis_i is 1, sources 1 to 7 are not taken on a sample but still become pending, and they are served once gdis_i drops. irq_o is also 0 while gdis_i is 1 and a source other than 0 is held.
- R9: The power-fail source (index 0) is taken and signalled regardless of gdis_i.
- R10: The base resets to 0 and is loaded from base_i on any cycle with base_we_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request lines, bit i for source i |
| off_i | input | 64 | Device offsets, byte i for source i |
| base_we_i | input | 1 | Base register write enable |
| base_i | input | 16 | New base address |
| sample_i | input | 1 | Strobe at the start of each fetch |
| ack_i | input | 1 | Acknowledge from the core |
| ack_idx_i | input | 3 | Index being acknowledged |
| gdis_i | input | 1 | Global disable (power fail exempt) |
| irq_o | output | 1 | Interrupt signalled to the core |
| vec_o | output | 16 | Handler address |
| idx_o | output | 3 | Index of the source being served |

## Verification
The bench targets the moments when the frozen vector could be disturbed. A new higher-priority request, a rewritten base and a changed offset all arrive while an interrupt is held. A design without the hold would show the new index or address before the acknowledge. It also sends an acknowledge with the wrong index. A design that ignored the index would drop irq_o and lose the request. Other corner cases are a level request held across its acknowledge, a request recorded while globally disabled, and power fail under the disable. A design that re-latched on level, dropped disabled requests or masked power fail would raise a second interrupt, raise none, or stay silent where the checks expect otherwise. Base-plus-offset sums that pass 0xFFFF catch an adder that is too wide or sign-extends.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } vic_st_e;
endpackage

// File: rtl/vic_pend.sv
module vic_pend #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] req_q;
  logic [N_SRC-1:0] pend_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        req_q[i] <= req_i[i];
        // new edge wins over a same-cycle clear
        pend_q[i] <= (pend_q[i] & ~clr_i[i]) | (req_i[i] & ~req_q[i]);
      end
    end

    assert_set_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[i]) |-> $past(req_i[i]));
    assert_clr_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_q[i]) |-> $past(clr_i[i]));
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N_SRC = 8,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] vld_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (vld_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |vld_i;

  always_comb begin
    if (any_o) assert_win_set_R5: assert (vld_i[idx_o]);
  end
endmodule

// File: rtl/vic_vec.sv
module vic_vec #(
  parameter int N_SRC  = 8,
  parameter int BASE_W = 16,
  parameter int OFF_W  = 8,
  parameter int IDX_W  = $clog2(N_SRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   base_we_i,
  input  logic [BASE_W-1:0]      base_i,
  input  logic [N_SRC*OFF_W-1:0] off_i,
  input  logic                   cap_i,
  input  logic [IDX_W-1:0]       win_i,
  output logic [BASE_W-1:0]      vec_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [OFF_W-1:0]  off_arr [N_SRC];
  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] sum;

  for (genvar i = 0; i < N_SRC; i++) begin : g_off
    assign off_arr[i] = off_i[i*OFF_W +: OFF_W];
  end

  assign sum = base_q + BASE_W'(off_arr[win_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (base_we_i) base_q <= base_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o <= '0;
      idx_o <= '0;
    end else if (cap_i) begin
      vec_o <= sum;
      idx_o <= win_i;
    end
  end

  assert_cap_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cap_i) |-> $stable(idx_o));
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int BASE_W = 16,
  parameter int OFF_W  = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*OFF_W-1:0] off_i,
  input  logic                   base_we_i,
  input  logic [BASE_W-1:0]      base_i,
  input  logic                   sample_i,
  input  logic                   ack_i,
  input  logic [IDX_W-1:0]       ack_idx_i,
  input  logic                   gdis_i,
  output logic                   irq_o,
  output logic [BASE_W-1:0]      vec_o,
  output logic [IDX_W-1:0]       idx_o
);
  localparam logic [N_SRC-1:0] PF_MASK = N_SRC'(1);

  vic_st_e          st_q;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] clr;
  logic [IDX_W-1:0] win;
  logic             any;
  logic             cap;
  logic             hit;
  logic             hold;

  assign hold = (st_q == ST_HOLD);
  assign elig = pend & (gdis_i ? PF_MASK : '1);
  assign cap  = sample_i & ~hold & any;
  assign hit  = hold & ack_i & (ack_idx_i == idx_o);
  assign clr  = hit ? (PF_MASK << idx_o) : '0;

  vic_pend #(.N_SRC(N_SRC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .clr_i (clr),
    .pend_o(pend)
  );

  vic_prio #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_prio (
    .vld_i(elig),
    .any_o(any),
    .idx_o(win)
  );

  vic_vec #(.N_SRC(N_SRC), .BASE_W(BASE_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_vec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .base_we_i(base_we_i),
    .base_i   (base_i),
    .off_i    (off_i),
    .cap_i    (cap),
    .win_i    (win),
    .vec_o    (vec_o),
    .idx_o    (idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else if (hit) st_q <= ST_IDLE;
    else if (cap) st_q <= ST_HOLD;
  end

  // power fail is exempt from the global disable
  assign irq_o = hold & (~gdis_i | (idx_o == '0));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold && $past(hold) |-> $stable(vec_o) && $stable(idx_o));
  assert_prio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold) |-> ($past(elig) & ((PF_MASK << idx_o) - PF_MASK)) == '0);
  assert_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold) |-> $past(sample_i));
  assert_dis_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && gdis_i |-> idx_o == '0);
  assert_pend_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |-> pend[idx_o]);
endmodule

// File: tb/sim_vic_top.sv
module sim_vic_top;
  localparam int N = 8;
  localparam int BW = 16;
  localparam int OW = 8;
  localparam int IW = 3;
  localparam int NV = 9;

  // {mask[28:21], gdis[20], base[19:4], exp_irq[3], exp_idx[2:0]}
  localparam logic [28:0] TBL [NV] = '{
    {8'h01, 1'b0, 16'h1000, 1'b1, 3'd0},
    {8'h80, 1'b0, 16'h2000, 1'b1, 3'd7},
    {8'hA4, 1'b0, 16'h0400, 1'b1, 3'd2},
    {8'hFE, 1'b0, 16'hFF80, 1'b1, 3'd1},
    {8'h60, 1'b1, 16'h3000, 1'b0, 3'd0},
    {8'h81, 1'b1, 16'h4000, 1'b1, 3'd0},
    {8'h00, 1'b0, 16'h5000, 1'b0, 3'd0},
    {8'hFF, 1'b0, 16'hFFF0, 1'b1, 3'd0},
    {8'hC0, 1'b0, 16'hFF80, 1'b1, 3'd6}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [OW-1:0] offs [N];
  logic [N*OW-1:0] off_flat;
  logic          base_we = 1'b0;
  logic [BW-1:0] base = '0;
  logic          sample = 1'b0;
  logic          ack = 1'b0;
  logic [IW-1:0] ack_idx = '0;
  logic          gdis = 1'b0;
  logic          irq;
  logic [BW-1:0] vec;
  logic [IW-1:0] idx;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) off_flat[i*OW +: OW] = offs[i];

  vic_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .off_i(off_flat),
    .base_we_i(base_we), .base_i(base), .sample_i(sample), .ack_i(ack),
    .ack_idx_i(ack_idx), .gdis_i(gdis), .irq_o(irq), .vec_o(vec), .idx_o(idx)
  );

  function automatic logic [OW-1:0] def_off(int i);
    return OW'(8'h20 * i + 8'h0F);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; sample = 1'b0; ack = 1'b0; gdis = 1'b0;
    base_we = 1'b0;
    for (int i = 0; i < N; i++) offs[i] = def_off(i);
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wbase(logic [BW-1:0] b);
    base_we = 1'b1; base = b; step(); base_we = 1'b0;
  endtask

  task automatic pulse(logic [N-1:0] m);
    req = m; step(); req = '0; step();
  endtask

  task automatic strobe();
    sample = 1'b1; step(); sample = 1'b0;
  endtask

  task automatic do_ack(logic [IW-1:0] i);
    ack = 1'b1; ack_idx = i; step(); ack = 1'b0;
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) offs[i] = def_off(i);
    step();

    // vector table: priority, disable, wrapping sums
    for (int k = 0; k < NV; k++) begin
      logic [28:0] e;
      logic [BW-1:0] ev;
      e = TBL[k];
      do_reset();
      wbase(e[19:4]);
      gdis = e[20];
      pulse(e[28:21]);
      strobe();
      chk("R5/R8 table irq", 32'(irq), 32'(e[3]));
      if (e[3]) begin
        ev = e[19:4] + BW'(def_off(int'(e[2:0])));
        chk("R5 table idx", 32'(idx), 32'(e[2:0]));
        chk("R6 table vec", 32'(vec), 32'(ev));
        do_ack(e[2:0]);
        chk("R3 table ack clears", 32'(irq), 0);
      end
    end

    // R1 reset state, R10 base reset value
    do_reset();
    chk("R1 irq", 32'(irq), 0);
    chk("R1 vec", 32'(vec), 0);
    chk("R1 idx", 32'(idx), 0);
    strobe();
    chk("R1 nothing pending", 32'(irq), 0);
    pulse(8'h20);
    strobe();
    chk("R10 base zero vec", 32'(vec), 32'h00AF);
    do_ack(3'd5);

    // R4 pending without strobe
    do_reset();
    wbase(16'h1000);
    pulse(8'h20);
    step(); step(); step();
    chk("R4 no strobe no irq", 32'(irq), 0);
    strobe();
    chk("R4 strobe irq", 32'(irq), 1);
    chk("R6 vec", 32'(vec), 32'h10AF);

    // R7 hold against new request, base and offset change
    wbase(16'h7000);
    offs[5] = 8'h55;
    pulse(8'h02);
    strobe();
    chk("R7 idx held", 32'(idx), 5);
    chk("R7 vec held", 32'(vec), 32'h10AF);
    offs[5] = def_off(5);

    // R3 wrong ack ignored
    do_ack(3'd2);
    chk("R3 wrong ack irq", 32'(irq), 1);
    chk("R3 wrong ack idx", 32'(idx), 5);
    do_ack(3'd5);
    chk("R3 right ack", 32'(irq), 0);
    strobe();
    chk("R5 next source", 32'(idx), 1);
    chk("R10 new base vec", 32'(vec), 32'h702F);
    do_ack(3'd1);

    // R2 level request
    do_reset();
    req = 8'h08; step();
    strobe();
    chk("R2 level taken", 32'(idx), 3);
    do_ack(3'd3);
    strobe();
    chk("R2 no relatch", 32'(irq), 0);
    req = '0; step();
    req = 8'h08; step();
    strobe();
    chk("R2 new edge", 32'(irq), 1);
    do_ack(3'd3);
    req = '0; step();

    // R8 disable
    do_reset();
    gdis = 1'b1;
    pulse(8'h10);
    strobe();
    chk("R8 disabled no irq", 32'(irq), 0);
    gdis = 1'b0;
    strobe();
    chk("R8 latched irq", 32'(irq), 1);
    chk("R8 latched idx", 32'(idx), 4);
    gdis = 1'b1; step();
    chk("R8 masked while held", 32'(irq), 0);
    gdis = 1'b0; step();
    chk("R8 unmasked", 32'(irq), 1);
    do_ack(3'd4);

    // R9 power fail under disable
    gdis = 1'b1;
    pulse(8'h05);
    strobe();
    chk("R9 pf irq", 32'(irq), 1);
    chk("R9 pf idx", 32'(idx), 0);
    do_ack(3'd0);
    strobe();
    chk("R9 others still masked", 32'(irq), 0);
    gdis = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule